// File: doc/BRIEF.md
# Multi-Format Integer Multiplier

A purely combinational multiplier for N-bit by M-bit integers. A 2-bit format select decides how both operands and the product are read: plain unsigned, sign-magnitude, ones' complement or two's complement. Both operands always use the same format, and the product is written back in that format. There is no clock, no register and no handshake. The product follows the operands and the format select after the propagation delay only.

Internally the block uses a single datapath for all four formats. Each operand is decoded into a sign flag and an unsigned magnitude. The two magnitudes go through an unsigned array multiplier. The product sign is the XOR of the operand signs. An encoder then writes the magnitude product back in the selected format.

Operand widths are set at elaboration. The narrower operand, `op_y`, drives the rows of the array, so M should not exceed N. The defaults are N = M = 4.

Top module: `mfm_multiplier`

## Requirements
- R1: With `fmt` = 2'b00, `prod` equals the unsigned product of `op_x` and `op_y`, for example 4'hF times 4'hF gives 8'hE1.
- R2: With `fmt` = 2'b01, the MSB of each operand is its sign and the lower bits are its magnitude. For nonzero magnitudes, `prod` bit N+M-1 is the XOR of the two operand MSBs, and bits N+M-2..0 hold the product of the magnitudes.
- R3: With `fmt` = 2'b01, if either operand magnitude is zero, `prod` is all zeros (positive zero). This holds for a negative zero operand too.
- R4: With `fmt` = 2'b10, an operand whose MSB is 1 has a magnitude equal to its bitwise inverse. A negative nonzero product is emitted as the bitwise inverse of the N+M-bit magnitude product.
- R5: With `fmt` = 2'b10, a zero product is emitted as all zeros. This covers an operand of all zeros and an operand of all ones (negative zero).
- R6: With `fmt` = 2'b11, `prod` equals the exact two's complement product of the operands. This includes the most negative value times itself, for example 4'h8 times 4'h8 gives 8'h40.
- R7: `prod` depends only on the present values of `op_x`, `op_y` and `fmt`. A change on any of them shows up on `prod` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | N | Multiplicand |
| op_y | input | M | Multiplier (the narrower operand) |
| fmt | input | 2 | Number format: 00 unsigned, 01 sign-magnitude, 10 ones' complement, 11 two's complement |
| prod | output | N+M | Product in the selected format |

## Verification
Every result is due in the same time step as its stimulus, zero cycles later, because no register lies between the inputs and `prod`. The bench applies each stimulus just after a falling clock edge and reads `prod` one time unit later. By then the combinational path has settled, and no rising edge has come between stimulus and sample. The R7 check changes an input between two edges and samples before the next edge, so any hidden register would show up as a stale product.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
  typedef enum logic [1:0] {
    FMT_UNSIGNED = 2'b00,
    FMT_SIGNMAG  = 2'b01,
    FMT_ONES     = 2'b10,
    FMT_TWOS     = 2'b11
  } fmt_e;
endpackage

// File: rtl/mfm_operand_decode.sv
// Splits one operand into a sign flag and an unsigned magnitude.
module mfm_operand_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0]  raw,
  input  mfm_pkg::fmt_e fmt,
  output logic          neg,
  output logic [W-1:0]  mag
);
  localparam int LW = W - 1;

  logic msb;
  assign msb = raw[W-1];

  always_comb begin
    neg = 1'b0;
    mag = raw;
    unique case (fmt)
      mfm_pkg::FMT_UNSIGNED: begin
        neg = 1'b0;
        mag = raw;
      end
      mfm_pkg::FMT_SIGNMAG: begin
        neg = msb;
        mag = {1'b0, raw[LW-1:0]};
      end
      mfm_pkg::FMT_ONES: begin
        neg = msb;
        mag = msb ? ~raw : raw;
      end
      mfm_pkg::FMT_TWOS: begin
        neg = msb;
        // the most negative value maps to 2^(W-1), which still fits in W bits
        mag = msb ? W'(~raw + W'(1)) : raw;
      end
      default: begin
        neg = 1'b0;
        mag = raw;
      end
    endcase
  end
endmodule

// File: rtl/mfm_array_mult.sv
// Unsigned shift-and-add array: one row per bit of the narrower operand b.
module mfm_array_mult #(
  parameter int AW = 4,
  parameter int BW = 4
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);
  localparam int PW = AW + BW;

  logic [PW-1:0] acc [BW+1];

  assign acc[0] = '0;

  for (genvar r = 0; r < BW; r++) begin : g_row
    logic [PW-1:0] part;
    assign part       = b[r] ? (PW'(a) << r) : '0;
    assign acc[r + 1] = acc[r] + part;
  end

  assign p = acc[BW];
endmodule

// File: rtl/mfm_result_encode.sv
// Writes a sign and an unsigned magnitude product back in the chosen format.
module mfm_result_encode #(
  parameter int PW = 8
) (
  input  mfm_pkg::fmt_e fmt,
  input  logic          neg,
  input  logic [PW-1:0] mag,
  output logic [PW-1:0] z
);
  logic nonzero;
  logic neg_nz;

  assign nonzero = |mag;
  // a zero magnitude always comes out as positive zero
  assign neg_nz  = neg & nonzero;

  always_comb begin
    z = mag;
    unique case (fmt)
      mfm_pkg::FMT_UNSIGNED: z = mag;
      mfm_pkg::FMT_SIGNMAG:  z = {neg_nz, mag[PW-2:0]};
      mfm_pkg::FMT_ONES:     z = neg_nz ? ~mag : mag;
      mfm_pkg::FMT_TWOS:     z = neg_nz ? PW'(~mag + PW'(1)) : mag;
      default:               z = mag;
    endcase
  end
endmodule

// File: rtl/mfm_multiplier.sv
// Combinational multiplier for four integer formats sharing one datapath.
module mfm_multiplier #(
  parameter int N = 4,
  parameter int M = 4
) (
  input  logic [N-1:0]   op_x,
  input  logic [M-1:0]   op_y,
  input  logic [1:0]     fmt,
  output logic [N+M-1:0] prod
);
  localparam int PW = N + M;

  mfm_pkg::fmt_e fmt_sel;
  logic          neg_x;
  logic          neg_y;
  logic          neg_p;
  logic [N-1:0]  mag_x;
  logic [M-1:0]  mag_y;
  logic [PW-1:0] mag_p;

  assign fmt_sel = mfm_pkg::fmt_e'(fmt);

  mfm_operand_decode #(.W(N)) u_dec_x (
    .raw(op_x), .fmt(fmt_sel), .neg(neg_x), .mag(mag_x)
  );

  mfm_operand_decode #(.W(M)) u_dec_y (
    .raw(op_y), .fmt(fmt_sel), .neg(neg_y), .mag(mag_y)
  );

  assign neg_p = neg_x ^ neg_y;

  mfm_array_mult #(.AW(N), .BW(M)) u_mult (
    .a(mag_x), .b(mag_y), .p(mag_p)
  );

  mfm_result_encode #(.PW(PW)) u_enc (
    .fmt(fmt_sel), .neg(neg_p), .mag(mag_p), .z(prod)
  );
endmodule

// File: rtl/mfm_multiplier_chk.sv
// Port-level checker bound to the multiplier.
module mfm_multiplier_chk #(
  parameter int N = 4,
  parameter int M = 4
) (
  input logic [N-1:0]   op_x,
  input logic [M-1:0]   op_y,
  input logic [1:0]     fmt,
  input logic [N+M-1:0] prod
);
  localparam int P = N + M;

  logic signed [P-1:0] sx, sy;
  logic [P-1:0]        ux, uy, smx, smy;
  logic                ones_zero;

  assign sx  = {{M{op_x[N-1]}}, op_x};
  assign sy  = {{N{op_y[M-1]}}, op_y};
  assign ux  = P'(op_x);
  assign uy  = P'(op_y);
  assign smx = P'(op_x[N-2:0]);
  assign smy = P'(op_y[M-2:0]);
  assign ones_zero = (op_x == '0) || (&op_x) || (op_y == '0) || (&op_y);

  always_comb begin
    if (fmt == 2'b00)
      p_unsigned_r1: assert (prod == P'(ux * uy))
        else $error("R1 unsigned product mismatch");
    if (fmt == 2'b01 && smx != '0 && smy != '0)
      p_smag_value_r2: assert (prod == {op_x[N-1] ^ op_y[M-1], (P-1)'(smx * smy)})
        else $error("R2 sign-magnitude product mismatch");
    if (fmt == 2'b01 && (smx == '0 || smy == '0))
      p_smag_zero_r3: assert (prod == '0)
        else $error("R3 sign-magnitude zero not positive");
    if (fmt == 2'b10 && !ones_zero)
      p_ones_sign_r4: assert (prod[P-1] == (op_x[N-1] ^ op_y[M-1]))
        else $error("R4 ones complement sign mismatch");
    if (fmt == 2'b10 && ones_zero)
      p_ones_zero_r5: assert (prod == '0)
        else $error("R5 ones complement zero not all zeros");
    if (fmt == 2'b11)
      p_twos_r6: assert (prod == P'(sx * sy))
        else $error("R6 two's complement product mismatch");
  end
endmodule

bind mfm_multiplier mfm_multiplier_chk #(.N(N), .M(M)) i_chk (
  .op_x(op_x), .op_y(op_y), .fmt(fmt), .prod(prod)
);

// File: tb/test_mfm_multiplier.sv
`timescale 1ns/1ps
module test_mfm_multiplier;
  localparam int BN = 4;
  localparam int BM = 4;
  localparam int BP = BN + BM;
  localparam int NVEC = 12;

  // entry: {fmt[1:0], x[3:0], y[3:0], expected[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'b00, 4'hF, 4'hF, 8'hE1},
    {2'b00, 4'hA, 4'h3, 8'h1E},
    {2'b00, 4'h0, 4'hF, 8'h00},
    {2'b01, 4'hB, 4'h5, 8'h8F},
    {2'b01, 4'hF, 4'hF, 8'h31},
    {2'b01, 4'h8, 4'h5, 8'h00},
    {2'b10, 4'hC, 4'h2, 8'hF9},
    {2'b10, 4'hF, 4'h7, 8'h00},
    {2'b10, 4'h8, 4'h8, 8'h31},
    {2'b11, 4'h8, 4'h8, 8'h40},
    {2'b11, 4'h8, 4'h7, 8'hC8},
    {2'b11, 4'hF, 4'h3, 8'hFD}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BN-1:0] op_x = '0;
  logic [BM-1:0] op_y = '0;
  logic [1:0]    fmt  = 2'b00;
  logic [BP-1:0] prod;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  mfm_multiplier #(.N(BN), .M(BM)) i_mfm_multiplier (
    .op_x(op_x), .op_y(op_y), .fmt(fmt), .prod(prod)
  );

  function automatic int decode(input logic [1:0] f, input int raw, input int w);
    int msb  = (raw >> (w - 1)) & 1;
    int low  = raw & ((1 << (w - 1)) - 1);
    int full = (1 << w) - 1;
    case (f)
      2'b00:   return raw;
      2'b01:   return msb ? -low : low;
      2'b10:   return msb ? -((~raw) & full) : raw;
      default: return msb ? raw - (1 << w) : raw;
    endcase
  endfunction

  function automatic logic [BP-1:0] model(input logic [1:0] f,
                                          input logic [BN-1:0] a,
                                          input logic [BM-1:0] b);
    int pv = decode(f, int'(a), BN) * decode(f, int'(b), BM);
    int mask = (1 << BP) - 1;
    case (f)
      2'b01:   return BP'((pv < 0) ? ((1 << (BP - 1)) | -pv) : pv);
      2'b10:   return BP'((pv < 0) ? ((~(-pv)) & mask) : pv);
      default: return BP'(pv & mask);
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'b00:   return "R1";
      2'b01:   return "R2/R3";
      2'b10:   return "R4/R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [BP-1:0] exp);
    checks++;
    if (prod !== exp) begin
      errors++;
      $display("FAIL %s: fmt=%b x=%h y=%h got %h expected %h",
               req, fmt, op_x, op_y, prod, exp);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [BN-1:0] a,
                       input logic [BM-1:0] b);
    @(negedge clk);
    fmt  = f;
    op_x = a;
    op_y = b;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // initial state: all-zero inputs give a zero product (R1)
    apply(2'b00, '0, '0);
    check("R1", '0);

    // hand-computed vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][17:16], VEC[i][15:12], VEC[i][11:8]);
      check(req_of(VEC[i][17:16]), VEC[i][7:0]);
    end

    // exhaustive sweep of every format and operand pair
    for (int f = 0; f < 4; f++) begin
      for (int a = 0; a < (1 << BN); a++) begin
        for (int b = 0; b < (1 << BM); b++) begin
          apply(2'(f), BN'(a), BM'(b));
          check(req_of(2'(f)), model(2'(f), BN'(a), BM'(b)));
        end
      end
    end

    // R3: negative zero times negative value gives positive zero
    apply(2'b01, 4'h8, 4'hF);
    check("R3", 8'h00);
    // R5: all-ones operand is zero in ones' complement
    apply(2'b10, 4'h5, 4'hF);
    check("R5", 8'h00);
    // R6: most negative times most negative
    apply(2'b11, 4'h8, 4'h8);
    check("R6", 8'h40);

    // R7: change inputs between clock edges, sample before the next edge
    @(posedge clk);
    #0.5;
    fmt = 2'b11; op_x = 4'hE; op_y = 4'h2;
    #0.5;
    check("R7", 8'hFC);
    fmt = 2'b00;
    #0.5;
    check("R7", 8'h1C);
    op_y = 4'h1;
    #0.5;
    check("R7", 8'h0E);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule